// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block takes an asynchronous serial line, finds the falling edge that opens each character, and builds a bit-timing reference from that edge. Each data bit, and the parity bit when one is configured, is sampled in the middle of its bit period. The assembled character is stored in a one-deep receive buffer. Half a bit later, at the middle of the stop bit, the block checks the stop bit and the parity. It then pulses a receive interrupt and updates three sticky error flags.

Software-facing logic around the block drives the enable and the configuration inputs, reads the buffer through a read strobe, and clears the error flags with a separate strobe. The configuration inputs must stay stable while a character is being received. A frame has one start bit (low), 5 to 8 data bits sent least significant bit first, an optional parity bit, and one stop bit (high). The bit period is `baud_div_i` system clocks, and the value must be at least 4.

When the enable is dropped before the buffer load, the character in flight is abandoned. Once the load has happened, dropping the enable no longer affects the buffered character.

Top module: `uart_rx_core`

## Requirements
- R1: While `en_i` is 0, no character is loaded and `irq_o` stays 0. Dropping `en_i` before the last data or parity bit has ended abandons the frame: `rx_data_o` and `rx_full_o` keep their previous values and no interrupt follows.
- R2: `rxd_i` passes through a two-flop synchronizer. A frame starts only on a high-to-low transition seen while idle and enabled. If the line is high again at the middle of the start bit, the event is discarded: no load and no interrupt.
- R3: One bit lasts `baud_div_i` clocks, and each bit is sampled at its middle. Data arrives LSB first. `len_sel_i` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Buffer bits above the selected length read 0.
- R4: `par_mode_i` selects the parity: 2'b00 none, 2'b01 even (data ones plus the parity bit give an even count), 2'b10 odd, and 2'b11 behaves as none. A mismatch sets `par_err_o`.
- R5: The buffer is loaded, and `rx_full_o` set, at the end of the last data or parity bit. `irq_o` is a one-cycle pulse that comes later, at the middle of the stop bit.
- R6: `frm_err_o` is set when the stop bit is sampled low. `par_err_o` and `frm_err_o` are set only in the cycle in which `irq_o` is high.
- R7: Loading a character while `rx_full_o` is 1 and `rd_i` is 0 sets `ovr_err_o`, and the new character replaces the old one. A pulse on `rd_i` clears `rx_full_o`.
- R8: The error flags stay set until `clr_err_i` is pulsed. If a flag is set and cleared in the same cycle, the set wins.
- R9: Dropping `en_i` after the buffer load but before the middle of the stop bit keeps the new character and `rx_full_o`, and suppresses `irq_o`.
- R10: After reset, `rx_data_o` is 0 and `rx_full_o`, all error flags and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial input line, idle high |
| en_i | input | 1 | Receive enable |
| len_sel_i | input | 2 | Data length code (5 to 8 bits) |
| par_mode_i | input | 2 | Parity mode code |
| baud_div_i | input | DIV_W | System clocks per bit |
| rd_i | input | 1 | Buffer read strobe |
| clr_err_i | input | 1 | Error flag clear strobe |
| rx_data_o | output | 8 | Receive buffer contents |
| rx_full_o | output | 1 | Buffer holds an unread character |
| par_err_o | output | 1 | Sticky parity error flag |
| ovr_err_o | output | 1 | Sticky overrun error flag |
| frm_err_o | output | 1 | Sticky framing error flag |
| irq_o | output | 1 | Receive interrupt pulse |

## Verification
Some rules hold on every cycle, and the assertions check them there. The interrupt is a single-cycle pulse and never appears while the block is disabled. Flags stay set until a clear. Parity and framing flags rise only together with the interrupt. The buffer contents change only when a character is loaded. Other behaviour only the bench scenarios can show. These are bit ordering and length masking, each parity mode, glitch rejection on the start bit, load ahead of the interrupt, overrun replacement, and the difference between dropping the enable before and after the buffer load.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam logic [1:0] PAR_NONE = 2'b00;
  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  // index of the final data bit for a length code (5..8 bits)
  function automatic logic [2:0] last_bit_idx(input logic [1:0] sel);
    return 3'd4 + {1'b0, sel};
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mid_o,
  output logic             end_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] half;

  assign half  = div_i >> 1;
  assign mid_o = run_i && (cnt_q == half - 1'b1);
  assign end_o = run_i && (cnt_q == div_i - 1'b1);

  always_comb begin
    if (!run_i || end_o) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              rxd_i,
  input  logic              mid_i,
  input  logic              end_i,
  input  logic [1:0]        len_sel_i,
  input  logic [1:0]        par_mode_i,
  input  logic              rd_i,
  input  logic              clr_err_i,
  output logic              run_o,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              pe_o,
  output logic              oe_o,
  output logic              fe_o,
  output logic              irq_o
);

  rx_state_e         state_q, state_d;
  logic [2:0]        idx_q, idx_d;
  logic [DATA_W-1:0] shr_q, shr_d, buf_q, buf_d;
  logic              pbit_q, pbit_d, pend_q, pend_d;
  logic              full_q, full_d, pe_q, pe_d, oe_q, oe_d, fe_q, fe_d;
  logic              irq_q, irq_d, prev_q;
  logic              load, check, par_on, odd_ones;

  assign par_on   = (par_mode_i == PAR_EVEN) || (par_mode_i == PAR_ODD);
  assign odd_ones = (^shr_q) ^ pbit_q;

  // next-state and datapath
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    shr_d   = shr_q;
    pbit_d  = pbit_q;
    load    = 1'b0;
    check   = 1'b0;
    if (!en_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (prev_q && !rxd_i) begin
          state_d = ST_START;
          shr_d   = '0;
          idx_d   = '0;
          pbit_d  = 1'b0;
        end
        ST_START: begin
          if (mid_i && rxd_i) state_d = ST_IDLE;
          else if (end_i)     state_d = ST_DATA;
        end
        ST_DATA: begin
          if (mid_i) shr_d[idx_q] = rxd_i;
          if (end_i) begin
            if (idx_q == last_bit_idx(len_sel_i)) begin
              if (par_on) state_d = ST_PAR;
              else begin
                load    = 1'b1;
                state_d = ST_STOP;
              end
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
        end
        ST_PAR: begin
          if (mid_i) pbit_d = rxd_i;
          if (end_i) begin
            load    = 1'b1;
            state_d = ST_STOP;
          end
        end
        ST_STOP: if (mid_i) begin
          check   = 1'b1;
          state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end

    pend_d = pend_q;
    buf_d  = buf_q;
    full_d = full_q;
    if (load) begin
      buf_d  = shr_q;
      full_d = 1'b1;
      pend_d = par_on && ((par_mode_i == PAR_EVEN) ? odd_ones : !odd_ones);
    end else if (rd_i) begin
      full_d = 1'b0;
    end

    pe_d = clr_err_i ? 1'b0 : pe_q;
    oe_d = clr_err_i ? 1'b0 : oe_q;
    fe_d = clr_err_i ? 1'b0 : fe_q;
    if (load && full_q && !rd_i) oe_d = 1'b1;
    if (check && pend_q)         pe_d = 1'b1;
    if (check && !rxd_i)         fe_d = 1'b1;
    irq_d = check;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shr_q   <= '0;
      pbit_q  <= 1'b0;
      pend_q  <= 1'b0;
      buf_q   <= '0;
      full_q  <= 1'b0;
      pe_q    <= 1'b0;
      oe_q    <= 1'b0;
      fe_q    <= 1'b0;
      irq_q   <= 1'b0;
      prev_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      shr_q   <= shr_d;
      pbit_q  <= pbit_d;
      pend_q  <= pend_d;
      buf_q   <= buf_d;
      full_q  <= full_d;
      pe_q    <= pe_d;
      oe_q    <= oe_d;
      fe_q    <= fe_d;
      irq_q   <= irq_d;
      prev_q  <= rxd_i;
    end
  end

  assign run_o  = (state_q != ST_IDLE);
  assign data_o = buf_q;
  assign full_o = full_q;
  assign pe_o   = pe_q;
  assign oe_o   = oe_q;
  assign fe_o   = fe_q;
  assign irq_o  = irq_q;

endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic              en_i,
  input  logic [1:0]        len_sel_i,
  input  logic [1:0]        par_mode_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic              rd_i,
  input  logic              clr_err_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              par_err_o,
  output logic              ovr_err_o,
  output logic              frm_err_o,
  output logic              irq_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n, rxd_s, run, mid_tick, end_tick;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  uart_rx_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (rxd_i),
    .q_o   (rxd_s)
  );

  uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run_i (run),
    .div_i (baud_div_i),
    .mid_o (mid_tick),
    .end_o (end_tick)
  );

  uart_rx_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en_i       (en_i),
    .rxd_i      (rxd_s),
    .mid_i      (mid_tick),
    .end_i      (end_tick),
    .len_sel_i  (len_sel_i),
    .par_mode_i (par_mode_i),
    .rd_i       (rd_i),
    .clr_err_i  (clr_err_i),
    .run_o      (run),
    .data_o     (rx_data_o),
    .full_o     (rx_full_o),
    .pe_o       (par_err_o),
    .oe_o       (ovr_err_o),
    .fe_o       (frm_err_o),
    .irq_o      (irq_o)
  );

endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       clr_err_i,
  input logic [7:0] rx_data_o,
  input logic       rx_full_o,
  input logic       par_err_o,
  input logic       ovr_err_o,
  input logic       frm_err_o,
  input logic       irq_o
);

  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_no_irq_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !irq_o);

  assert_par_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_o && !clr_err_i |=> par_err_o);

  assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err_o && !clr_err_i |=> ovr_err_o);

  assert_frm_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_err_o && !clr_err_i |=> frm_err_o);

  assert_frm_with_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_err_o) |-> irq_o);

  assert_par_with_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err_o) |-> irq_o);

  assert_data_only_on_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_data_o) |-> rx_full_o);

endmodule

bind uart_rx_core uart_rx_core_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_i      (en_i),
  .clr_err_i (clr_err_i),
  .rx_data_o (rx_data_o),
  .rx_full_o (rx_full_o),
  .par_err_o (par_err_o),
  .ovr_err_o (ovr_err_o),
  .frm_err_o (frm_err_o),
  .irq_o     (irq_o)
);

// File: tb/uart_rx_core_tb_top.sv
module uart_rx_core_tb_top;

  localparam int CLK_P = 10;
  localparam int BIT   = 16;
  localparam int NVEC  = 6;

  // {data, len code, parity mode, bad parity, stop level, expected data, exp pe, exp fe}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'hA5, 2'd3, 2'd0, 1'b0, 1'b1, 8'hA5, 1'b0, 1'b0},
    {8'h3C, 2'd3, 2'd1, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0},
    {8'h5A, 2'd3, 2'd2, 1'b1, 1'b1, 8'h5A, 1'b1, 1'b0},
    {8'hFF, 2'd0, 2'd0, 1'b0, 1'b1, 8'h1F, 1'b0, 1'b0},
    {8'h6B, 2'd2, 2'd1, 1'b0, 1'b0, 8'h6B, 1'b0, 1'b1},
    {8'hED, 2'd1, 2'd2, 1'b0, 1'b1, 8'h2D, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rxd, en, rd, clr;
  logic [1:0]  len_sel, par_mode;
  logic [15:0] baud_div;
  logic [7:0]  rx_data;
  logic        rx_full, par_err, ovr_err, frm_err, irq;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  logic [7:0] snap_data;
  int snap_irq;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) if (irq) irq_cnt++;

  uart_rx_core dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxd_i      (rxd),
    .en_i       (en),
    .len_sel_i  (len_sel),
    .par_mode_i (par_mode),
    .baud_div_i (baud_div),
    .rd_i       (rd),
    .clr_err_i  (clr),
    .rx_data_o  (rx_data),
    .rx_full_o  (rx_full),
    .par_err_o  (par_err),
    .ovr_err_o  (ovr_err),
    .frm_err_o  (frm_err),
    .irq_o      (irq)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  // abort: 0 none, 1 drop enable during data bit 3, 2 drop enable early in stop bit
  task automatic send_frame(input logic [7:0] d, input logic [1:0] ls, input logic [1:0] pm,
                            input logic badp, input logic stopv, input int abort);
    int nb;
    logic [7:0] mask;
    logic p;
    nb = 5 + int'(ls);
    mask = 8'hFF >> (8 - nb);
    p = ^(d & mask);
    if (pm == 2'd2) p = ~p;
    if (badp) p = ~p;
    len_sel = ls;
    par_mode = pm;
    @(negedge clk) rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      if (abort == 1 && i == 3) en = 1'b0;
      repeat (BIT) @(negedge clk);
    end
    if (pm == 2'd1 || pm == 2'd2) begin
      rxd = p;
      repeat (BIT) @(negedge clk);
    end
    rxd = stopv;
    repeat (6) @(negedge clk);
    snap_data = rx_data;
    snap_irq = irq_cnt;
    if (abort == 2) en = 1'b0;
    repeat (BIT - 6) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1'b0; rxd = 1'b1; en = 1'b0; rd = 1'b0; clr = 1'b0;
    len_sel = 2'd3; par_mode = 2'd0; baud_div = 16'(BIT);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 data", int'(rx_data), 0);
    check("R10 full", int'(rx_full), 0);
    check("R10 flags", int'({par_err, ovr_err, frm_err}), 0);
    check("R10 irq", irq_cnt, 0);
    en = 1'b1;
    repeat (2) @(negedge clk);

    // table-driven frames: R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      pulse_clr();
      base = irq_cnt;
      send_frame(VEC[v][23:16], VEC[v][15:14], VEC[v][13:12], VEC[v][11], VEC[v][10], 0);
      check("R3 data", int'(rx_data), int'(VEC[v][9:2]));
      check("R4 parity flag", int'(par_err), int'(VEC[v][1]));
      check("R6 framing flag", int'(frm_err), int'(VEC[v][0]));
      check("R5 one irq", irq_cnt, base + 1);
      check("R5 loaded before irq data", int'(snap_data), int'(VEC[v][9:2]));
      check("R5 loaded before irq count", snap_irq, base);
      check("R7 full after load", int'(rx_full), 1);
      check("R7 no overrun", int'(ovr_err), 0);
      pulse_rd();
      check("R7 read clears full", int'(rx_full), 0);
    end
    pulse_clr();

    // R2 start glitch
    base = irq_cnt;
    @(negedge clk) rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    check("R2 glitch no irq", irq_cnt, base);
    check("R2 glitch no load", int'(rx_full), 0);

    // R7 overrun
    send_frame(8'h11, 2'd3, 2'd0, 1'b0, 1'b1, 0);
    send_frame(8'h22, 2'd3, 2'd0, 1'b0, 1'b1, 0);
    check("R7 overrun flag", int'(ovr_err), 1);
    check("R7 newer data kept", int'(rx_data), 8'h22);

    // R8 sticky then clear
    pulse_rd();
    send_frame(8'h44, 2'd3, 2'd0, 1'b0, 1'b1, 0);
    check("R8 overrun stays set", int'(ovr_err), 1);
    pulse_clr();
    check("R8 clear strobe", int'({par_err, ovr_err, frm_err}), 0);
    pulse_rd();

    // R1 disabled reception
    base = irq_cnt;
    en = 1'b0;
    send_frame(8'h77, 2'd3, 2'd0, 1'b0, 1'b1, 0);
    check("R1 disabled no irq", irq_cnt, base);
    check("R1 disabled no load", int'(rx_full), 0);
    check("R1 disabled data kept", int'(rx_data), 8'h44);

    // R1 enable dropped mid data
    send_frame(8'h99, 2'd3, 2'd0, 1'b0, 1'b1, 1);
    check("R1 abort no irq", irq_cnt, base);
    check("R1 abort data kept", int'(rx_data), 8'h44);
    check("R1 abort no load", int'(rx_full), 0);

    // R9 enable dropped after load
    send_frame(8'h5C, 2'd3, 2'd0, 1'b0, 1'b1, 2);
    check("R9 new data kept", int'(rx_data), 8'h5C);
    check("R9 full kept", int'(rx_full), 1);
    check("R9 irq suppressed", irq_cnt, base);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule